// File: doc/BRIEF.md
# Mask Compress/Expand Unit

This block rearranges the elements of one vector under control of a per-element mask. In pack mode it gathers the elements whose mask bit is set and lays them out side by side from element 0 of the result. In unpack mode it does the reverse: it takes source elements one after another and drops each into the next position whose mask bit is set.

A request supplies the source vector, the mask, an active length and the destination's current contents as flat buses. The unit takes a private copy of these and then visits one element index per clock, lowest index first. When the scan ends it raises a one-cycle `done` and reports how many elements were moved. The result vector and the count stay on the outputs until the next request is accepted, so the surrounding datapath can write them back to its register file at leisure.

Top module: `vmce_unit`

## Requirements
- R1: After reset `busy`, `done`, `count` and every bit of `dst_vec` are 0.
- R2: With `op` = 0 (pack), the active source elements whose mask bit is 1 appear at `dst_vec` elements 0, 1, 2, ... in rising source-index order.
- R3: In pack mode, result elements at index `count` and above hold the matching `dst_init` element captured at the start.
- R4: With `op` = 1 (unpack), the k-th source element (k from 0) is written to the position of the k-th active mask bit that is set, counting from index 0.
- R5: In unpack mode, every result position whose active mask bit is 0 holds the matching `dst_init` element.
- R6: In both modes `count` at `done` equals the number of set mask bits below the effective length.
- R7: Only indices below the effective length take part, where the effective length is `vl` limited to N. Mask bits at or above it have no effect. A length of 0 gives `count` = 0 and a result equal to `dst_init`.
- R8: A request is taken on a clock edge where `start` = 1 and `busy` = 0. With effective length L, `busy` is 1 for exactly L cycles after that edge. `done` is 1 for exactly the one cycle that follows the L-th edge after it, and for L = 0 that is the cycle right after the accepting edge.
- R9: A `start` seen while `busy` = 1 is ignored. The running request completes with its own operands and timing.
- R10: While `busy` = 0 and no request is taken, `count` and `dst_vec` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new operation |
| op | input | 1 | 0 = pack (compress), 1 = unpack (expand) |
| vl | input | $clog2(N+1) | Requested vector length |
| mask | input | N | One mask bit per element |
| src_vec | input | N*W | Source elements, element i at bits [i*W +: W] |
| dst_init | input | N*W | Prior destination contents, same layout |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| count | output | $clog2(N+1) | Number of elements moved |
| dst_vec | output | N*W | Result vector, same layout |

## Verification
A wrong scan index or select counter moves elements to the wrong slot or in the wrong order. That error is visible on `dst_vec` in the first idle cycle after `done`, and the `count` comparison exposes a skipped or doubled increment in the same cycle. An off-by-one in the end-of-scan test moves `busy` or `done` by a whole cycle, and the per-clock comparison of those two flags against a countdown model catches it at the exact edge. Corrupted captured operands after an ignored `start` show up as a wrong result for the request that was already running.

// File: rtl/vmce_pkg.sv
package vmce_pkg;

    typedef enum logic {
        VM_PACK   = 1'b0,
        VM_UNPACK = 1'b1
    } vm_op_e;

endpackage

// File: rtl/vmce_mask_gate.sv
// Qualifies mask bits with the vector length and counts the survivors.
module vmce_mask_gate #(
    parameter int N  = 8,
    parameter int LW = $clog2(N + 1)
) (
    input  logic [N-1:0]  mask,
    input  logic [LW-1:0] vl,
    output logic [N-1:0]  active,
    output logic [LW-1:0] pop
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        assign active[g] = mask[g] & (LW'(g) < vl);
    end

    always_comb begin
        pop = '0;
        for (int i = 0; i < N; i++) begin
            pop = pop + LW'(active[i]);
        end
    end

endmodule

// File: rtl/vmce_elem_pick.sv
// Selects one W-bit element out of a flat N-element bus.
module vmce_elem_pick #(
    parameter int N  = 8,
    parameter int W  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N*W-1:0] vec,
    input  logic [IW-1:0]  sel,
    output logic [W-1:0]   elem
);

    logic [W-1:0] lanes [N];

    for (genvar g = 0; g < N; g++) begin : g_lane
        assign lanes[g] = vec[g*W +: W];
    end

    assign elem = lanes[sel];

endmodule

// File: rtl/vmce_unit.sv
module vmce_unit
    import vmce_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     op,
    input  logic [$clog2(N+1)-1:0]   vl,
    input  logic [N-1:0]             mask,
    input  logic [N*W-1:0]           src_vec,
    input  logic [N*W-1:0]           dst_init,
    output logic                     busy,
    output logic                     done,
    output logic [$clog2(N+1)-1:0]   count,
    output logic [N*W-1:0]           dst_vec
);

    localparam int IW = $clog2(N);
    localparam int LW = $clog2(N + 1);

    typedef struct packed {
        logic            busy;
        logic            done;
        vm_op_e          op;
        logic [IW-1:0]   idx;
        logic [LW-1:0]   k;
        logic [LW-1:0]   len;
        logic [LW-1:0]   pop;
        logic [N-1:0]    act;
        logic [N*W-1:0]  src;
        logic [N*W-1:0]  dst;
    } st_t;

    st_t st_q, st_d;

    logic [LW-1:0] vl_eff;
    logic [N-1:0]  gate_act;
    logic [LW-1:0] gate_pop;
    logic [IW-1:0] rd_sel;
    logic [IW-1:0] wr_pos;
    logic [W-1:0]  rd_elem;
    logic          last_elem;

    assign vl_eff = (vl > LW'(N)) ? LW'(N) : vl;

    vmce_mask_gate #(.N(N), .LW(LW)) u_gate (
        .mask   (mask),
        .vl     (vl_eff),
        .active (gate_act),
        .pop    (gate_pop)
    );

    // Pack reads at the scan index and writes at the select count;
    // unpack swaps the two roles.
    assign rd_sel = (st_q.op == VM_PACK) ? st_q.idx : st_q.k[IW-1:0];
    assign wr_pos = (st_q.op == VM_PACK) ? st_q.k[IW-1:0] : st_q.idx;

    vmce_elem_pick #(.N(N), .W(W), .IW(IW)) u_pick (
        .vec  (st_q.src),
        .sel  (rd_sel),
        .elem (rd_elem)
    );

    assign last_elem = (LW'(st_q.idx) == (st_q.len - LW'(1)));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.op  = vm_op_e'(op);
                st_d.idx = '0;
                st_d.k   = '0;
                st_d.len = vl_eff;
                st_d.act = gate_act;
                st_d.pop = gate_pop;
                st_d.src = src_vec;
                st_d.dst = dst_init;
                if (vl_eff == '0) begin
                    st_d.done = 1'b1;
                end else begin
                    st_d.busy = 1'b1;
                end
            end
        end else begin
            if (st_q.act[st_q.idx]) begin
                for (int j = 0; j < N; j++) begin
                    if (IW'(j) == wr_pos) begin
                        st_d.dst[j*W +: W] = rd_elem;
                    end
                end
                st_d.k = st_q.k + LW'(1);
            end
            if (last_elem) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + IW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign count   = st_q.k;
    assign dst_vec = st_q.dst;

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r6_count_matches_pop: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (count == st_q.pop));

    a_r7_scan_in_length: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (LW'(st_q.idx) < st_q.len));

    a_r2_select_le_index: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st_q.k <= LW'(st_q.idx)));

    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(st_q.op) && $stable(st_q.len) && $stable(st_q.src));

    a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(dst_vec) && $stable(count)));

endmodule

// File: tb/tb_vmce_unit.sv
module tb_vmce_unit;

    localparam int N  = 8;
    localparam int W  = 8;
    localparam int LW = $clog2(N + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            op = 1'b0;
    logic [LW-1:0]   vl = '0;
    logic [N-1:0]    mask = '0;
    logic [N*W-1:0]  src_vec = '0;
    logic [N*W-1:0]  dst_init = '0;
    logic            busy;
    logic            done;
    logic [LW-1:0]   count;
    logic [N*W-1:0]  dst_vec;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string cur_req = "R1";
    bit check_en = 1'b0;

    // reference model state
    bit             m_busy = 1'b0;
    bit             m_done = 1'b0;
    int             m_left = 0;
    int             m_cnt = 0;
    logic [N*W-1:0] m_dst = '0;
    int             p_cnt = 0;
    logic [N*W-1:0] p_dst = '0;

    always #4 clk = ~clk;

    vmce_unit #(.N(N), .W(W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op       (op),
        .vl       (vl),
        .mask     (mask),
        .src_vec  (src_vec),
        .dst_init (dst_init),
        .busy     (busy),
        .done     (done),
        .count    (count),
        .dst_vec  (dst_vec)
    );

    task automatic compute_expected();
        int vle;
        int q[$];
        int k;
        vle = (int'(vl) > N) ? N : int'(vl);
        for (int i = 0; i < vle; i++) begin
            if (mask[i]) q.push_back(int'(src_vec[i*W +: W]));
        end
        p_dst = dst_init;
        p_cnt = q.size();
        if (op == 1'b0) begin
            for (int j = 0; j < q.size(); j++) p_dst[j*W +: W] = W'(q[j]);
        end else begin
            k = 0;
            for (int i = 0; i < vle; i++) begin
                if (mask[i]) begin
                    p_dst[i*W +: W] = src_vec[k*W +: W];
                    k++;
                end
            end
        end
        m_left = vle;
    endtask

    always @(posedge clk) begin
        cycles++;
        m_done = 1'b0;
        if (!rst_n) begin
            m_busy = 1'b0;
            m_cnt  = 0;
            m_dst  = '0;
        end else if (m_busy) begin
            m_left--;
            if (m_left == 0) begin
                m_busy = 1'b0;
                m_done = 1'b1;
                m_cnt  = p_cnt;
                m_dst  = p_dst;
            end
        end else if (start) begin
            compute_expected();
            if (m_left == 0) begin
                m_done = 1'b1;
                m_cnt  = p_cnt;
                m_dst  = p_dst;
            end else begin
                m_busy = 1'b1;
            end
        end
    end

    task automatic check(string req, string what, logic [N*W-1:0] act, logic [N*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (check_en) begin
            check("R8", "busy", {{(N*W-1){1'b0}}, busy}, {{(N*W-1){1'b0}}, m_busy});
            check("R8", "done", {{(N*W-1){1'b0}}, done}, {{(N*W-1){1'b0}}, m_done});
            if (!m_busy) begin
                check("R6", "count", {{(N*W-LW){1'b0}}, count}, (N*W)'(m_cnt));
                check(cur_req, "dst_vec", dst_vec, m_dst);
            end
        end
    end

    task automatic issue(input logic o, input int l, input logic [N-1:0] m,
                         input logic [N*W-1:0] s, input logic [N*W-1:0] d);
        @(negedge clk);
        op = o; vl = LW'(l); mask = m; src_vec = s; dst_init = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_op(input string req, input logic o, input int l, input logic [N-1:0] m,
                          input logic [N*W-1:0] s, input logic [N*W-1:0] d);
        cur_req = req;
        issue(o, l, m, s, d);
        repeat (N + 2) @(negedge clk);
        cur_req = "R10";
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [N*W-1:0] ramp(int base);
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(base + i);
        return v;
    endfunction

    initial begin : watchdog
        wait (cycles > 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "busy", {{(N*W-1){1'b0}}, busy}, '0);
        check("R1", "done", {{(N*W-1){1'b0}}, done}, '0);
        check("R1", "count", {{(N*W-LW){1'b0}}, count}, '0);
        check("R1", "dst_vec", dst_vec, '0);
        rst_n = 1'b1;
        check_en = 1'b1;
        @(negedge clk);

        // R2 R3: pack with a sparse mask
        run_op("R2 R3", 1'b0, 8, 8'b1011_0010, ramp(8'h10), ramp(8'hA0));
        // R4 R5: unpack with the same mask
        run_op("R4 R5", 1'b1, 8, 8'b1011_0010, ramp(8'h10), ramp(8'hA0));
        // all ones / all zeros
        run_op("R2", 1'b0, 8, 8'hFF, ramp(8'h30), ramp(8'hC0));
        run_op("R4", 1'b1, 8, 8'hFF, ramp(8'h30), ramp(8'hC0));
        run_op("R3", 1'b0, 8, 8'h00, ramp(8'h30), ramp(8'hC0));
        run_op("R5", 1'b1, 8, 8'h00, ramp(8'h30), ramp(8'hC0));
        // R7: mask bits above the length ignored, zero length, clamped length
        run_op("R7", 1'b0, 5, 8'b1110_0101, ramp(8'h50), ramp(8'hE0));
        run_op("R7", 1'b1, 5, 8'b1110_0101, ramp(8'h50), ramp(8'hE0));
        run_op("R7", 1'b0, 0, 8'hFF, ramp(8'h50), ramp(8'hE0));
        run_op("R7", 1'b1, 15, 8'b0101_0101, ramp(8'h60), ramp(8'hF0));
        run_op("R8", 1'b0, 1, 8'h01, ramp(8'h70), ramp(8'h00));

        // R9: second start during a running scan is ignored
        cur_req = "R9";
        issue(1'b0, 8, 8'b1100_0011, ramp(8'h21), ramp(8'h81));
        @(negedge clk);
        op = 1'b1; vl = LW'(3); mask = 8'hFF; src_vec = ramp(8'h01); dst_init = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (N + 2) @(negedge clk);

        // back-to-back requests as soon as the unit is idle
        cur_req = "R8";
        issue(1'b1, 3, 8'b0000_0110, ramp(8'h11), ramp(8'h44));
        wait (!m_busy);
        issue(1'b0, 4, 8'b0000_1010, ramp(8'h22), ramp(8'h55));
        repeat (N + 2) @(negedge clk);

        // random mixes
        for (int t = 0; t < 40; t++) begin
            logic [N*W-1:0] s, d;
            for (int i = 0; i < N; i++) begin
                s[i*W +: W] = W'($urandom);
                d[i*W +: W] = W'($urandom);
            end
            run_op(($urandom % 2) ? "R4 R5" : "R2 R3", 1'($urandom), int'($urandom % 10),
                   N'($urandom), s, d);
        end

        check_en = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule